// File: doc/BRIEF.md
# Pin I/O Controller with Edge Capture

This block controls a bank of general-purpose pins behind a single-cycle, word-addressed register bus. Software sets each pin's direction and drives outputs without a read-modify-write. One register raises bits and a separate register lowers them. A pin can also be given to a peripheral, which then drives the pad in place of the output latch.

Each input is synchronized before use. Rising and falling transitions can be captured per pin, each under its own enable, into sticky status bits. Software clears a status bit by writing a 1 to it. The OR of all status bits forms a single interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the direction, output latch, both edge enables, edge status and peripheral-select registers are zero, and `pin_oe_o`, `pin_o` and `irq_o` are zero.
- R2: The word address selects a register: 0 pin level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status, 7 peripheral select.
- R3: The level register returns each pin's input after a two-flop synchronizer, with 1 meaning high. A new pin value shows on the second rising clock edge after it is applied. Writes to the level register change nothing.
- R4: Direction bit 1 makes the pin an output, and `pin_oe_o` follows the direction register. The register reads back as written.
- R5: Writing the set register raises every latch bit where the write data has a 1. Bits where the data has a 0 keep their value.
- R6: Writing the clear register lowers every latch bit where the write data has a 1. Bits where the data has a 0 keep their value. Reads of the set and clear registers return zero.
- R7: With a pin's rising enable at 1, a low-to-high transition of the synchronized input sets that pin's status bit.
- R8: With a pin's falling enable at 1, a high-to-low transition of the synchronized input sets that pin's status bit.
- R9: A transition whose enable is 0 leaves the status unchanged.
- R10: Status bits are sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R11: When an enabled transition and a status clear hit the same bit in the same cycle, the bit stays set.
- R12: `irq_o` is 1 exactly when at least one status bit is 1.
- R13: Peripheral-select bit 1 drives that pin's `pin_o` from `alt_out_i`. Bit 0 drives it from the output latch, which keeps its value while the pin is handed over.
- R14: Register bits at and above the pin count (bits 28 to 31 by default) read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per access |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pin_i | input | 28 | Pad input levels |
| pin_o | output | 28 | Pad output values |
| pin_oe_o | output | 28 | Pad output enables |
| alt_out_i | input | 28 | Peripheral output values |
| irq_o | output | 1 | Interrupt, OR of all status bits |

## Verification
The bench builds the block with its default parameters: 28 pins, a 32-bit register word and two synchronizer stages. With these values the top pin (27) can be exercised on its falling edge. All-ones writes expose the reserved upper nibble. The fixed two-stage depth lets the bench line up a status clear with the exact cycle in which a captured transition lands, which is the case covered by R11.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL = 3'd0,
    A_DIR   = 3'd1,
    A_SET   = 3'd2,
    A_CLR   = 3'd3,
    A_RISE  = 3'd4,
    A_FALL  = 3'd5,
    A_STAT  = 3'd6,
    A_ALT   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NP = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NP-1:0]     wdata_i,
  output logic [NP-1:0]     dir_o,
  output logic [NP-1:0]     out_o,
  output logic [NP-1:0]     rise_o,
  output logic [NP-1:0]     fall_o,
  output logic [NP-1:0]     alt_o,
  output logic [NP-1:0]     stat_clr_o
);
  logic [7:0] hit;

  for (genvar a = 0; a < 8; a++) begin : g_dec
    assign hit[a] = we_i && (addr_i == ADDR_W'(a));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      out_o  <= '0;
      rise_o <= '0;
      fall_o <= '0;
      alt_o  <= '0;
    end else begin
      if (hit[A_DIR])  dir_o  <= wdata_i;
      if (hit[A_RISE]) rise_o <= wdata_i;
      if (hit[A_FALL]) fall_o <= wdata_i;
      if (hit[A_ALT])  alt_o  <= wdata_i;
      if (hit[A_SET])       out_o <= out_o | wdata_i;
      else if (hit[A_CLR])  out_o <= out_o & ~wdata_i;
    end
  end

  assign stat_clr_o = hit[A_STAT] ? wdata_i : '0;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int NP = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] sync_i,
  input  logic [NP-1:0] rise_en_i,
  input  logic [NP-1:0] fall_en_i,
  input  logic [NP-1:0] clr_i,
  output logic [NP-1:0] stat_o
);
  logic [NP-1:0] prev_q, hit;

  assign hit = (sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_o <= '0;
    end else begin
      prev_q <= sync_i;
      // new edge overrides a same-cycle clear
      stat_o <= (stat_o & ~clr_i) | hit;
    end
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_PINS-1:0] alt_out_i,
  output logic                irq_o
);
  localparam int PAD_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] sync_q, dir_q, out_q, rise_q, fall_q, alt_q, stat_clr, stat_q;
  logic [NUM_PINS-1:0] rd_bits;
  logic [PAD_W-1:0]    unused_hi;

  assign unused_hi = bus_wdata_i[REG_W-1:NUM_PINS];

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_q)
  );

  gpio_regs #(.NP(NUM_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i[NUM_PINS-1:0]),
    .dir_o     (dir_q),
    .out_o     (out_q),
    .rise_o    (rise_q),
    .fall_o    (fall_q),
    .alt_o     (alt_q),
    .stat_clr_o(stat_clr)
  );

  gpio_edge #(.NP(NUM_PINS)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_q),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .clr_i    (stat_clr),
    .stat_o   (stat_q)
  );

  always_comb begin
    unique case (reg_addr_e'(bus_addr_i))
      A_LEVEL: rd_bits = sync_q;
      A_DIR:   rd_bits = dir_q;
      A_RISE:  rd_bits = rise_q;
      A_FALL:  rd_bits = fall_q;
      A_STAT:  rd_bits = stat_q;
      A_ALT:   rd_bits = alt_q;
      default: rd_bits = '0;
    endcase
  end

  assign bus_rdata_o = {{PAD_W{1'b0}}, rd_bits};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    assign pin_o[p] = alt_q[p] ? alt_out_i[p] : out_q[p];
  end

  assign pin_oe_o = dir_q;
  assign irq_o    = |stat_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 28
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [REG_W-1:0]    bus_wdata_i,
  input logic [REG_W-1:0]    bus_rdata_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] out_q,
  input logic [NUM_PINS-1:0] stat_q
);
  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_SET) |=>
      ((out_q & $past(bus_wdata_i[NUM_PINS-1:0])) == $past(bus_wdata_i[NUM_PINS-1:0])));

  assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_CLR) |=> ((out_q & $past(bus_wdata_i[NUM_PINS-1:0])) == '0));

  assert_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_DIR) |=> (pin_oe_o == $past(bus_wdata_i[NUM_PINS-1:0])));

  assert_level_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_LEVEL) |=> ($stable(out_q) && $stable(pin_oe_o)));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_rsvd_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[REG_W-1:NUM_PINS] == '0);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .pin_oe_o   (pin_oe_o),
  .out_q      (out_q),
  .stat_q     (stat_q)
);

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;
  localparam int NP = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin = '0;
  logic [NP-1:0] pout, poe;
  logic [NP-1:0] alt_out = '0;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin), .pin_o(pout),
    .pin_oe_o(poe), .alt_out_i(alt_out), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 pin_o", 32'(pout), 0);
    chk("R1 pin_oe_o", 32'(poe), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);
    chk("R14 dir reserved", v, 32'h0FFF_FFFF);
    chk("R4 oe all", 32'(poe), 32'h0FFF_FFFF);
    wr(3'd1, 32'h0000_00A5);
    rd(3'd1, v);
    chk("R4 dir readback", v, 32'hA5);
    chk("R4 oe", 32'(poe), 32'hA5);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(3'd2, 32'h3);
    chk("R5 set", 32'(pout), 32'h3);
    wr(3'd2, 32'h4);
    chk("R5 set keeps zeros", 32'(pout), 32'h7);
    wr(3'd3, 32'h1);
    chk("R6 clear", 32'(pout), 32'h6);
    rd(3'd2, v);
    chk("R6 set reads zero", v, 0);
    rd(3'd3, v);
    chk("R6 clear reads zero", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk);
    pin = 28'h800_0001;
    rd(3'd0, v);
    chk("R3 not yet synced", v, 0);
    rd(3'd0, v);
    chk("R3 level after two edges", v, 32'h0800_0001);
    wr(3'd0, 32'h0000_FFFF);
    rd(3'd0, v);
    chk("R3 level write ignored", v, 32'h0800_0001);
    chk("R3 outputs untouched", 32'(pout), 32'h6);
    pin = '0;
    settle();
    rd(3'd6, v);
    chk("R9 no enables no status", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(3'd4, 32'h8);
    rd(3'd4, v);
    chk("R2 rise enable readback", v, 32'h8);
    @(negedge clk); pin = 28'h8;
    settle();
    rd(3'd6, v);
    chk("R7 rising captured", v, 32'h8);
    chk("R12 irq set", 32'(irq), 1);
    wr(3'd6, 32'h0);
    rd(3'd6, v);
    chk("R10 write zero keeps", v, 32'h8);
    wr(3'd6, 32'h8);
    rd(3'd6, v);
    chk("R10 write one clears", v, 0);
    chk("R12 irq clear", 32'(irq), 0);
    @(negedge clk); pin = '0;
    settle();
    rd(3'd6, v);
    chk("R9 falling not enabled", v, 0);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(3'd5, 32'h0800_0000);
    @(negedge clk); pin = 28'h800_0000;
    settle();
    rd(3'd6, v);
    chk("R9 rising not enabled", v, 0);
    @(negedge clk); pin = '0;
    settle();
    rd(3'd6, v);
    chk("R8 falling captured pin27", v, 32'h0800_0000);
    chk("R12 irq", 32'(irq), 1);
    wr(3'd6, 32'h0800_0000);
    rd(3'd6, v);
    chk("R10 cleared", v, 0);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(3'd4, 32'h20);
    wr(3'd5, 32'h20);
    @(negedge clk); pin = 28'h20;
    settle();
    rd(3'd6, v);
    chk("R7 both enables rising", v, 32'h20);
    @(negedge clk); pin = '0;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 3'd6; wdata = 32'h20;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    rd(3'd6, v);
    chk("R11 edge beats clear", v, 32'h20);
    wr(3'd6, 32'h20);
    rd(3'd6, v);
    chk("R10 clear after collision", v, 0);
    chk("R12 irq low", 32'(irq), 0);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_alt();
    logic [31:0] v;
    alt_out = 28'h1;
    wr(3'd7, 32'h3);
    rd(3'd7, v);
    chk("R13 alt readback", v, 32'h3);
    chk("R13 alt drives pins", 32'(pout), 32'h5);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v);
    chk("R14 alt reserved", v, 32'h0FFF_FFFF);
    chk("R13 all handed over", 32'(pout), 32'h1);
    wr(3'd7, 32'h0);
    chk("R13 latch kept", 32'(pout), 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_setclr();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_alt();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule